// File: doc/BRIEF.md
# Burst Memory Wait-State Controller

This block runs the memory side of one burst access to a synchronous NOR-flash or pseudo-static RAM bank. A host hands over a request through a valid/ready port. The request carries a start address, a direction, a beat count and write data. The controller then holds the bank selected and counts an initial latency. After that it moves data beats and holds back whenever the memory's wait line asks for a stall. Read beats return to the host with a valid strobe. Write beats are marked by a per-beat pulse, and the host's write data is passed straight through to the memory.

Static configuration inputs control the access. Read bursts and write bursts have separate enables. An access whose direction is not enabled for bursts falls back to a single unclocked beat. Further inputs set:

- whether the wait line is used at all,
- which level of the wait line means "wait",
- whether a wait warns one data cycle ahead or marks the stalled cycle itself,
- whether writes to the bank are permitted,
- whether writes take their latency from a separate write timing value.

A forbidden write never selects the memory and ends with an error pulse.

Top module: `burst_wait_seq`

## Requirements
- R1: After reset, `mem_cs_n` is 1, `req_ready` is 1, and `rsp_valid` and `rsp_err` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Number the cycles after that edge 0, 1, 2 and so on. Cycles 0 to L-1 are latency cycles, where L is the selected latency. Data cycles start at cycle L. Every data cycle that is not a stall carries one beat. An accepted burst carries `req_len`+1 beats (`req_len` holds beats minus one). The read data of a beat is captured from `mem_rdata` in its own cycle and shows on `rsp_data` with `rsp_valid` high in the following cycle.
- R3: The wait input has no effect during latency cycles, whatever its level.
- R4: When `cfg_wait_en` is 0, the wait input is ignored and no stall is inserted.
- R5: When `cfg_wait_during` is 1, a data cycle in which wait is active carries no beat. That beat is repeated in the next data cycle. A write beat is marked by `wr_beat` high during its cycle.
- R6: When `cfg_wait_during` is 0, wait active in a data cycle makes the next data cycle a stall without a beat. Wait seen in the final beat's cycle has no effect.
- R7: The wait input is active when its level equals `cfg_wait_pol` (1 means active high, 0 means active low).
- R8: A write with `cfg_wr_burst` at 0 is done as a single beat. `mem_clk_en` stays 0 and the wait input is ignored. With `cfg_wr_burst` at 1, `mem_clk_en` is 1 throughout the selected cycles.
- R9: A read uses bursts only if `cfg_rd_burst` is 1, whatever the value of `cfg_wr_burst`. Otherwise it is a single beat with `mem_clk_en` at 0 and wait ignored.
- R10: A write accepted while `cfg_wr_en` is 0 never drives `mem_cs_n` low. `rsp_err` is 1 in cycle 0 only, and `rsp_valid` stays 0.
- R11: The latency for writes is `cfg_wr_lat` when `cfg_ext_mode` is 1 and `cfg_rd_lat` otherwise. Reads always use `cfg_rd_lat`.
- R12: `mem_cs_n` is 0 exactly from cycle 0 through the cycle of the last beat. It is 1 for at least two cycles after that. `req_ready` is 1 only while the memory is deselected and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared by host and memory sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW (16) | Burst start address |
| req_len | input | LENW (4) | Beats in the burst minus one |
| req_wdata | input | DW (16) | Write data for the current beat |
| cfg_rd_burst | input | 1 | Synchronous burst enable for reads |
| cfg_wr_burst | input | 1 | Synchronous burst enable for writes |
| cfg_wait_en | input | 1 | Use the wait input |
| cfg_wait_pol | input | 1 | Level of the wait input that means wait |
| cfg_wait_during | input | 1 | 1: wait marks the stall cycle, 0: wait warns one cycle ahead |
| cfg_wr_en | input | 1 | Writes permitted in the bank |
| cfg_ext_mode | input | 1 | Writes use the separate write latency |
| cfg_rd_lat | input | LATW (4) | Shared / read initial latency in cycles |
| cfg_wr_lat | input | LATW (4) | Write initial latency in cycles |
| mem_cs_n | output | 1 | Bank select, active low |
| mem_clk_en | output | 1 | Memory clock enable for synchronous accesses |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW (16) | Latched start address |
| mem_wdata | output | DW (16) | Write data to memory |
| mem_rdata | input | DW (16) | Read data from memory |
| mem_wait | input | 1 | Wait request from memory |
| wr_beat | output | 1 | A write beat is taken this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW (16) | Read data |
| rsp_err | output | 1 | Forbidden write terminated |

## Verification
The bench makes the memory return a read value that encodes the current cycle number. The list of returned values therefore shows exactly which cycles were taken as beats. Directed wait patterns are then compared against each other:

- Wait held only during latency separates a design that samples wait too early from a correct one.
- The same mid-burst pattern under the two warning modes separates stall-this-cycle from stall-next-cycle.
- Inverting the polarity with the same logical pattern exposes level handling.

Single-beat fallbacks, a forbidden write and a split read/write latency check the direction-dependent choices. Random configurations, lengths and wait densities then mix all of these.

// File: rtl/bws_pkg.sv
package bws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LAT  = 2'd1,
      ST_DATA = 2'd2,
      ST_GAP  = 2'd3
   } bws_state_e;
endpackage

// File: rtl/bws_latency.sv
module bws_latency #(
   parameter int LATW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [LATW-1:0] lat_val,
   input  logic            run,
   output logic            done
);
   logic [LATW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (lat_val == '0) ? '0 : lat_val - 1'b1;
      end else if (run && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/bws_wait.sv
module bws_wait (
   input  logic clk,
   input  logic rst_n,
   input  logic in_data,
   input  logic sync,
   input  logic wait_en,
   input  logic wait_pol,
   input  logic wait_during,
   input  logic mem_wait,
   output logic take
);
   logic wait_act;
   logic stall_nxt_q;

   assign wait_act = in_data & sync & wait_en & (mem_wait == wait_pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stall_nxt_q <= 1'b0;
      else if (!in_data) stall_nxt_q <= 1'b0;
      else               stall_nxt_q <= wait_act;
   end

   assign take = in_data & (wait_during ? ~wait_act : ~stall_nxt_q);
endmodule

// File: rtl/bws_beats.sv
module bws_beats #(
   parameter int LENW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [LENW-1:0] len,
   input  logic            take,
   output logic            last
);
   logic [LENW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rem_q <= '0;
      else if (load)                    rem_q <= len;
      else if (take && rem_q != '0)     rem_q <= rem_q - 1'b1;
   end

   assign last = (rem_q == '0);
endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq #(
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int LENW    = 4,
   parameter int LATW    = 4,
   parameter bit RSP_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [LENW-1:0] req_len,
   input  logic [DW-1:0]   req_wdata,
   input  logic            cfg_rd_burst,
   input  logic            cfg_wr_burst,
   input  logic            cfg_wait_en,
   input  logic            cfg_wait_pol,
   input  logic            cfg_wait_during,
   input  logic            cfg_wr_en,
   input  logic            cfg_ext_mode,
   input  logic [LATW-1:0] cfg_rd_lat,
   input  logic [LATW-1:0] cfg_wr_lat,
   output logic            mem_cs_n,
   output logic            mem_clk_en,
   output logic            mem_oe_n,
   output logic            mem_we_n,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   input  logic            mem_wait,
   output logic            wr_beat,
   output logic            rsp_valid,
   output logic [DW-1:0]   rsp_data,
   output logic            rsp_err
);
   import bws_pkg::*;

   if (LATW < 4) begin : g_bad_latw
      $error("LATW must be at least 4");
   end
   if (LENW < 1 || AW < 1 || DW < 1) begin : g_bad_width
      $error("LENW, AW and DW must be positive");
   end

   bws_state_e      state_q;
   logic            wr_q;
   logic            sync_q;
   logic            err_q;
   logic [AW-1:0]   addr_q;
   logic            accept;
   logic            refuse;
   logic            start;
   logic            sync_sel;
   logic [LATW-1:0] lat_sel;
   logic [LENW-1:0] len_sel;
   logic            lat_done;
   logic            take;
   logic            last;
   logic            active;
   logic            rd_take;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid & req_ready;
   assign refuse    = accept & req_write & ~cfg_wr_en;
   assign start     = accept & ~refuse;
   assign sync_sel  = req_write ? cfg_wr_burst : cfg_rd_burst;
   assign lat_sel   = (req_write && cfg_ext_mode) ? cfg_wr_lat : cfg_rd_lat;
   assign len_sel   = sync_sel ? req_len : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         sync_q  <= 1'b0;
         err_q   <= 1'b0;
         addr_q  <= '0;
      end else begin
         err_q <= refuse;
         unique case (state_q)
            ST_IDLE: begin
               if (refuse) begin
                  state_q <= ST_GAP;
               end else if (start) begin
                  wr_q    <= req_write;
                  sync_q  <= sync_sel;
                  addr_q  <= req_addr;
                  state_q <= (lat_sel == '0) ? ST_DATA : ST_LAT;
               end
            end
            ST_LAT:  if (lat_done)     state_q <= ST_DATA;
            ST_DATA: if (take && last) state_q <= ST_GAP;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   bws_latency #(.LATW(LATW)) i_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .lat_val (lat_sel),
      .run     (state_q == ST_LAT),
      .done    (lat_done)
   );

   bws_wait i_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_data     (state_q == ST_DATA),
      .sync        (sync_q),
      .wait_en     (cfg_wait_en),
      .wait_pol    (cfg_wait_pol),
      .wait_during (cfg_wait_during),
      .mem_wait    (mem_wait),
      .take        (take)
   );

   bws_beats #(.LENW(LENW)) i_beats (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .len   (len_sel),
      .take  (take),
      .last  (last)
   );

   assign active     = (state_q == ST_LAT) || (state_q == ST_DATA);
   assign mem_cs_n   = ~active;
   assign mem_clk_en = active & sync_q;
   assign mem_oe_n   = ~(active & ~wr_q);
   assign mem_we_n   = ~(active & wr_q);
   assign mem_addr   = addr_q;
   assign mem_wdata  = req_wdata;
   assign wr_beat    = take & wr_q;
   assign rd_take    = take & ~wr_q;
   assign rsp_err    = err_q;

   if (RSP_REG) begin : g_rsp_reg
      logic          v_q;
      logic [DW-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= rd_take;
            if (rd_take) d_q <= mem_rdata;
         end
      end
      assign rsp_valid = v_q;
      assign rsp_data  = d_q;
   end else begin : g_rsp_comb
      assign rsp_valid = rd_take;
      assign rsp_data  = mem_rdata;
   end
endmodule

// File: rtl/bws_chk.sv
module bws_chk #(
   parameter bit RSP_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic mem_cs_n,
   input logic mem_clk_en,
   input logic mem_oe_n,
   input logic mem_we_n,
   input logic wr_beat,
   input logic rsp_valid,
   input logic rsp_err
);
   // R12
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_cs_n);

   // R12
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |=> mem_cs_n);

   // R10
   err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (mem_cs_n && !rsp_valid));

   // R8
   clk_en_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_clk_en |-> !mem_cs_n);

   // R5
   wr_beat_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_beat |-> (!mem_we_n && mem_oe_n));

   // R2
   rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (RSP_REG ? $past(!mem_oe_n) : !mem_oe_n));
endmodule

bind burst_wait_seq bws_chk #(.RSP_REG(RSP_REG)) i_bws_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .mem_cs_n   (mem_cs_n),
   .mem_clk_en (mem_clk_en),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .wr_beat    (wr_beat),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err)
);

// File: tb/test_burst_wait_seq.sv
module test_burst_wait_seq;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int LENW = 4;
   localparam int LATW = 4;
   localparam logic [DW-1:0] BASE = 16'h4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LENW-1:0] req_len = '0;
   logic [DW-1:0] req_wdata = '0;
   logic cfg_rd_burst = 1'b1, cfg_wr_burst = 1'b1, cfg_wait_en = 1'b1;
   logic cfg_wait_pol = 1'b1, cfg_wait_during = 1'b0, cfg_wr_en = 1'b1;
   logic cfg_ext_mode = 1'b0;
   logic [LATW-1:0] cfg_rd_lat = 4'd2, cfg_wr_lat = 4'd2;
   logic [DW-1:0] mem_rdata = '0;
   logic mem_wait = 1'b0;
   logic req_ready, mem_cs_n, mem_clk_en, mem_oe_n, mem_we_n, wr_beat;
   logic rsp_valid, rsp_err;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, rsp_data;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int exp_idx[64];
   int obs_idx[64];
   int exp_n, obs_n, exp_end;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   burst_wait_seq #(.AW(AW), .DW(DW), .LENW(LENW), .LATW(LATW)) i_burst_wait_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .req_wdata(req_wdata), .cfg_rd_burst(cfg_rd_burst),
      .cfg_wr_burst(cfg_wr_burst), .cfg_wait_en(cfg_wait_en),
      .cfg_wait_pol(cfg_wait_pol), .cfg_wait_during(cfg_wait_during),
      .cfg_wr_en(cfg_wr_en), .cfg_ext_mode(cfg_ext_mode),
      .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
      .mem_cs_n(mem_cs_n), .mem_clk_en(mem_clk_en), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_wait(mem_wait), .wr_beat(wr_beat),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
      end
   endtask

   // Expected beat cycles from the requirements (R2..R11)
   task automatic model(input bit wr, input int len, input logic [127:0] wv);
      bit sync, err, pend, eff, beat;
      int lat, nb;
      sync = wr ? cfg_wr_burst : cfg_rd_burst;
      err  = wr && !cfg_wr_en;
      lat  = (wr && cfg_ext_mode) ? int'(cfg_wr_lat) : int'(cfg_rd_lat);
      nb   = sync ? len + 1 : 1;
      exp_n = 0;
      exp_end = -1;
      pend = 1'b0;
      if (!err) begin
         for (int c = 0; c < 128; c++) begin
            if (c < lat) continue;
            eff  = cfg_wait_en && sync && wv[c];
            beat = cfg_wait_during ? !eff : !pend;
            pend = eff;
            if (beat) begin
               exp_idx[exp_n] = c;
               exp_n++;
               if (exp_n == nb) begin
                  exp_end = c;
                  break;
               end
            end
         end
      end
   endtask

   // wv holds the logical wait pattern per cycle after acceptance
   task automatic run_txn(input bit wr, input int len, input logic [127:0] wv, input string rq);
      bit err, sync, cs_ok, ce_ok, seq_ok;
      int last, bad_c;
      err  = wr && !cfg_wr_en;
      sync = wr ? cfg_wr_burst : cfg_rd_burst;
      model(wr, len, wv);
      last = (exp_end < 0) ? 3 : exp_end + 3;
      obs_n = 0;
      cs_ok = 1'b1;
      ce_ok = 1'b1;
      bad_c = -1;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_len   = LENW'(len);
      req_addr  = AW'($urandom);
      mem_wait  = !cfg_wait_pol;
      chk(req_ready === 1'b1, {rq, " R12 ready before request"}, int'(req_ready), 1);
      @(posedge clk);
      for (int c = 0; c <= last; c++) begin
         @(negedge clk);
         if (c == 0) req_valid = 1'b0;
         if (c == 0) chk(rsp_err === err, {rq, " R10 error pulse"}, int'(rsp_err), int'(err));
         else if (rsp_err !== 1'b0) chk(1'b0, {rq, " R10 error only once"}, int'(rsp_err), 0);
         if (rsp_valid === 1'b1 && obs_n < 64) begin
            obs_idx[obs_n] = int'(rsp_data - BASE);
            obs_n++;
         end
         mem_wait  = wv[c] ? cfg_wait_pol : !cfg_wait_pol;
         mem_rdata = BASE + DW'(c);
         req_wdata = DW'(16'h9000 + c);
         #1;
         if (mem_cs_n !== !(!err && c <= exp_end)) begin
            cs_ok = 1'b0;
            if (bad_c < 0) bad_c = c;
         end
         if (mem_clk_en !== (sync && !err && c <= exp_end)) ce_ok = 1'b0;
         if (wr_beat === 1'b1 && obs_n < 64) begin
            obs_idx[obs_n] = c;
            obs_n++;
         end
      end
      chk(cs_ok, {rq, " R12 select window, first bad cycle"}, bad_c, -1);
      chk(ce_ok, {rq, " R8 R9 clock enable"}, 0, 1);
      seq_ok = (obs_n == exp_n);
      for (int i = 0; i < exp_n && seq_ok; i++)
         if (obs_idx[i] != exp_idx[i]) seq_ok = 1'b0;
      chk(obs_n == exp_n, {rq, " R2 beat count"}, obs_n, exp_n);
      if (exp_n > 0 && obs_n > 0)
         chk(seq_ok, {rq, " R2 first beat cycle"}, obs_idx[0], exp_idx[0]);
      if (exp_n > 0 && obs_n == exp_n)
         chk(seq_ok, {rq, " R2 last beat cycle"}, obs_idx[obs_n-1], exp_idx[exp_n-1]);
   endtask

   task automatic set_cfg(input bit rdb, input bit wrb, input bit wen, input bit pol,
                          input bit dur, input bit wre, input bit ext,
                          input int rl, input int wl);
      cfg_rd_burst = rdb; cfg_wr_burst = wrb; cfg_wait_en = wen;
      cfg_wait_pol = pol; cfg_wait_during = dur; cfg_wr_en = wre;
      cfg_ext_mode = ext; cfg_rd_lat = LATW'(rl); cfg_wr_lat = LATW'(wl);
   endtask

   initial begin
      logic [127:0] wv;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(mem_cs_n === 1'b1, "R1 cs after reset", int'(mem_cs_n), 1);
      chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
      chk(rsp_err === 1'b0, "R1 rsp_err after reset", int'(rsp_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 plain read burst
      set_cfg(1, 1, 1, 1, 0, 1, 0, 3, 3);
      run_txn(1'b0, 3, '0, "R2 read len4 lat3");
      set_cfg(1, 1, 1, 1, 0, 1, 0, 0, 0);
      run_txn(1'b0, 0, '0, "R2 read single lat0");
      // R3 wait only during latency
      set_cfg(1, 1, 1, 1, 1, 1, 0, 5, 5);
      run_txn(1'b0, 3, 128'h1F, "R3 wait in latency");
      // R4 wait disabled
      set_cfg(1, 1, 0, 1, 1, 1, 0, 2, 2);
      run_txn(1'b0, 4, {128{1'b1}}, "R4 wait disabled");
      // R5 during-stall mode
      set_cfg(1, 1, 1, 1, 1, 1, 0, 2, 2);
      run_txn(1'b0, 3, 128'b0011_0100, "R5 during read");
      run_txn(1'b1, 3, 128'b0011_0100, "R5 during write");
      // R6 ahead mode, same pattern
      set_cfg(1, 1, 1, 1, 0, 1, 0, 2, 2);
      run_txn(1'b0, 3, 128'b0011_0100, "R6 ahead read");
      run_txn(1'b0, 1, 128'b1000, "R6 wait on last beat");
      // R7 active-low wait
      set_cfg(1, 1, 1, 0, 0, 1, 0, 1, 1);
      run_txn(1'b0, 3, 128'b0110, "R7 active low");
      // R8 asynchronous write fallback
      set_cfg(1, 0, 1, 1, 1, 1, 0, 2, 2);
      run_txn(1'b1, 5, {128{1'b1}}, "R8 async write");
      // R9 read burst disabled, write burst enabled
      set_cfg(0, 1, 1, 1, 1, 1, 0, 2, 2);
      run_txn(1'b0, 5, {128{1'b1}}, "R9 async read");
      // R10 forbidden write
      set_cfg(1, 1, 1, 1, 0, 0, 0, 2, 2);
      run_txn(1'b1, 3, '0, "R10 write refused");
      // R11 extended mode latencies
      set_cfg(1, 1, 1, 1, 0, 1, 1, 1, 6);
      run_txn(1'b1, 2, '0, "R11 ext write lat");
      run_txn(1'b0, 2, '0, "R11 ext read lat");
      set_cfg(1, 1, 1, 1, 0, 1, 0, 1, 6);
      run_txn(1'b1, 2, '0, "R11 shared lat");

      // random mix
      for (int t = 0; t < 80; t++) begin
         int dens;
         set_cfg($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 4) != 0, $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 5) != 0,
                 $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 15));
         dens = $urandom_range(0, 3);
         for (int b = 0; b < 128; b++)
            wv[b] = (b < 90) && ($urandom_range(0, 7) < dens);
         run_txn($urandom_range(0, 1), $urandom_range(0, 15), wv, "R2 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule